// File: doc/BRIEF.md
# Voltage-Select Code Decoder with Pin Pull-Down Control

This block turns a four-level control code, sampled from external pins, into the enable and the target output voltage of a step-down regulator. An all-low code switches the regulator off. Any other code switches it on and selects one of fifteen fixed setpoints. The setpoint is reported in millivolts. No separate enable pin exists; the code itself is the enable.

The block also owns the weak pull-down of every control pin. Pull-downs hold an undriven pin low after power-up. A pin's pull-down is let go once that pin has been seen high, and all of them come back when the code returns to all-low or when the input supply is too low to trust. When the code leaves all-low, a one-clock start pulse tells the soft-start sequencer to begin a fresh ramp. A move from one nonzero code to another only retargets the setpoint.

Top module: `vsel_code_ctrl`

## Requirements
- R1: `reg_en` is 0 while the synchronised code is 4'b0000 and 1 for any other code.
- R2: With pin bit 3 as the most significant bit, codes 1 to 15 give `setpoint_mv` values of 800, 1000, 1200, 1400, 1500, 1600, 1800, 2300, 2350, 2000, 2400, 2450, 2800, 3000 and 3300 in that order.
- R3: `setpoint_mv` is 0 after reset. While the code is all-low it keeps the last nonzero-code value.
- R4: During reset all bits of `pd_en` are 1, and `reg_en` and `start_pulse` are 0.
- R5: Bit i of `pd_en` drops to 0 once pin i is seen high. It stays 0 while the code is nonzero, even if pin i then goes low again.
- R6: All `pd_en` bits return to 1 when the code is all-low.
- R7: While `supply_ok` is 0, all `pd_en` bits are 1.
- R8: A change from the all-low code to any nonzero code raises `start_pulse` for exactly one clock, in the same cycle that `reg_en` rises.
- R9: A change between two nonzero codes updates `setpoint_mv` and leaves `start_pulse` at 0.
- R10: A pin change reaches `reg_en`, `setpoint_mv`, `pd_en` and `start_pulse` on the third rising clock edge after it is applied: two synchroniser flops plus one output register. A change of `supply_ok` takes effect on `pd_en` at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 4 | Asynchronous control pin levels, bit 3 most significant |
| supply_ok | input | 1 | Input supply above its low threshold, synchronous to clk |
| reg_en | output | 1 | Regulator enable |
| setpoint_mv | output | 12 | Target output voltage in millivolts |
| pd_en | output | 4 | Per-pin weak pull-down enable, 1 = engaged |
| start_pulse | output | 1 | One-clock soft-start launch |

## Verification
The assertions assume `supply_ok` is already synchronous to `clk`. They also assume a code change is meant to be read only after it has passed through the synchroniser. Bit skew across pins is therefore not modelled as a fault. The bench drives every pin and `supply_ok` on the falling edge, and it changes all four pins at the same moment. Each new code is held for at least three edges before it is sampled, so no intermediate code is ever seen.

// File: rtl/vsel_pkg.sv
`timescale 1ns/1ps
package vsel_pkg;
   // Number of control pins; the setpoint table is built for exactly this many.
   localparam int unsigned VSEL_PINS   = 4;
   localparam int unsigned VSEL_CODES  = 1 << VSEL_PINS;
   // Setpoint limits in millivolts, used by range checks.
   localparam int unsigned VSEL_MV_MIN = 800;
   localparam int unsigned VSEL_MV_MAX = 3300;
   // Minimum width that holds VSEL_MV_MAX.
   localparam int unsigned VSEL_MV_W   = $clog2(VSEL_MV_MAX + 1);
endpackage

// File: rtl/vsel_sync.sv
`timescale 1ns/1ps
module vsel_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("vsel_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("vsel_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[LAST];
endmodule

// File: rtl/vsel_decode.sv
`timescale 1ns/1ps
module vsel_decode
   import vsel_pkg::*;
#(
   parameter int unsigned NPIN = VSEL_PINS,
   parameter int unsigned MV_W = 12
) (
   input  logic [NPIN-1:0] code,
   output logic            nonzero,
   output logic [MV_W-1:0] mv
);
   if (NPIN != VSEL_PINS) begin : g_bad_npin
      $error("vsel_decode: table is defined for four pins only");
   end
   if (MV_W < VSEL_MV_W || MV_W > 16) begin : g_bad_mvw
      $error("vsel_decode: MV_W must hold 3300 and be at most 16");
   end

   logic [15:0] mv_full;

   always_comb begin
      unique case (code)
         4'h1:    mv_full = 16'd800;
         4'h2:    mv_full = 16'd1000;
         4'h3:    mv_full = 16'd1200;
         4'h4:    mv_full = 16'd1400;
         4'h5:    mv_full = 16'd1500;
         4'h6:    mv_full = 16'd1600;
         4'h7:    mv_full = 16'd1800;
         4'h8:    mv_full = 16'd2300;
         4'h9:    mv_full = 16'd2350;
         4'hA:    mv_full = 16'd2000;
         4'hB:    mv_full = 16'd2400;
         4'hC:    mv_full = 16'd2450;
         4'hD:    mv_full = 16'd2800;
         4'hE:    mv_full = 16'd3000;
         4'hF:    mv_full = 16'd3300;
         default: mv_full = 16'd0;
      endcase
   end

   assign nonzero = |code;
   assign mv      = mv_full[MV_W-1:0];

   always_comb begin
      if (nonzero) begin
         AST_MV_IN_RANGE: assert (mv_full >= 16'(VSEL_MV_MIN) && mv_full <= 16'(VSEL_MV_MAX)); // R2
      end
   end
endmodule

// File: rtl/vsel_pulldown.sv
`timescale 1ns/1ps
module vsel_pulldown #(
   parameter int unsigned NPIN = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            supply_ok,
   input  logic [NPIN-1:0] code,
   output logic [NPIN-1:0] pd_en
);
   if (NPIN < 1) begin : g_bad_npin
      $error("vsel_pulldown: NPIN must be at least 1");
   end

   logic all_low;
   assign all_low = (code == '0);

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pd_en[i] <= 1'b1;
         else if (!supply_ok) pd_en[i] <= 1'b1;
         else if (all_low)    pd_en[i] <= 1'b1;
         else if (code[i])    pd_en[i] <= 1'b0;
      end

      AST_PD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
         (supply_ok && code[i]) |=> !pd_en[i]); // R5
      AST_PD_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         (supply_ok && !all_low && !pd_en[i]) |=> !pd_en[i]); // R5
   end

   AST_PD_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      all_low |=> (&pd_en)); // R6
   AST_PD_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (&pd_en)); // R7
endmodule

// File: rtl/vsel_code_ctrl.sv
`timescale 1ns/1ps
module vsel_code_ctrl
   import vsel_pkg::*;
#(
   parameter int unsigned NPIN        = VSEL_PINS,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MV_W        = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin_lvl,
   input  logic            supply_ok,
   output logic            reg_en,
   output logic [MV_W-1:0] setpoint_mv,
   output logic [NPIN-1:0] pd_en,
   output logic            start_pulse
);
   if (NPIN != VSEL_PINS) begin : g_bad_npin
      $error("vsel_code_ctrl: NPIN must equal the package pin count");
   end

   logic [NPIN-1:0] code_s;
   logic            code_nz;
   logic [MV_W-1:0] code_mv;

   vsel_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_lvl),
      .q_sync  (code_s)
   );

   vsel_decode #(.NPIN(NPIN), .MV_W(MV_W)) i_decode (
      .code    (code_s),
      .nonzero (code_nz),
      .mv      (code_mv)
   );

   vsel_pulldown #(.NPIN(NPIN)) i_pulldown (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .code      (code_s),
      .pd_en     (pd_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_en      <= 1'b0;
         start_pulse <= 1'b0;
         setpoint_mv <= '0;
      end else begin
         reg_en      <= code_nz;
         start_pulse <= code_nz && !reg_en;
         if (code_nz) setpoint_mv <= code_mv;
      end
   end

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse); // R8
   AST_START_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> reg_en); // R8
   AST_SETPOINT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_en |=> (reg_en || $stable(setpoint_mv))); // R3
   AST_EN_HAS_SETPOINT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_en |-> (setpoint_mv != '0)); // R1
endmodule

// File: tb/test_vsel_code_ctrl.sv
`timescale 1ns/1ps
module test_vsel_code_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pin_lvl = 4'h0;
   logic        supply_ok = 1'b1;
   logic        reg_en;
   logic [11:0] setpoint_mv;
   logic [3:0]  pd_en;
   logic        start_pulse;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   vsel_code_ctrl i_vsel_code_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_lvl     (pin_lvl),
      .supply_ok   (supply_ok),
      .reg_en      (reg_en),
      .setpoint_mv (setpoint_mv),
      .pd_en       (pd_en),
      .start_pulse (start_pulse)
   );

   function automatic int exp_mv(input logic [3:0] c);
      case (c)
         4'h1: return 800;   4'h2: return 1000;  4'h3: return 1200;
         4'h4: return 1400;  4'h5: return 1500;  4'h6: return 1600;
         4'h7: return 1800;  4'h8: return 2300;  4'h9: return 2350;
         4'hA: return 2000;  4'hB: return 2400;  4'hC: return 2450;
         4'hD: return 2800;  4'hE: return 3000;  4'hF: return 3300;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive a code on the falling edge, wait out sync + output register.
   task automatic apply(input logic [3:0] c);
      @(negedge clk) pin_lvl = c;
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      #1;
      chk(reg_en == 1'b0,      "R4 reg_en",  int'(reg_en), 0);
      chk(start_pulse == 1'b0, "R4 start",   int'(start_pulse), 0);
      chk(pd_en == 4'hF,       "R4 pd_en",   int'(pd_en), 15);
      chk(setpoint_mv == 0,    "R3 reset sp", int'(setpoint_mv), 0);
   endtask

   task automatic t_first_enable;
      apply(4'h1);
      chk(reg_en == 1'b1,      "R1 enable",  int'(reg_en), 1);
      chk(start_pulse == 1'b1, "R8 start",   int'(start_pulse), 1);
      chk(setpoint_mv == 800,  "R2 sp 0001", int'(setpoint_mv), 800);
      chk(pd_en == 4'hE,       "R5 pd release", int'(pd_en), 14);
      @(posedge clk); #1;
      chk(start_pulse == 1'b0, "R8 one cycle", int'(start_pulse), 0);
   endtask

   task automatic t_walk_codes;
      for (int c = 2; c < 16; c++) begin
         apply(4'(c));
         chk(setpoint_mv == 12'(exp_mv(4'(c))), "R2 map", int'(setpoint_mv), exp_mv(4'(c)));
         chk(start_pulse == 1'b0, "R9 no restart", int'(start_pulse), 0);
         chk(reg_en == 1'b1,      "R1 stays on", int'(reg_en), 1);
      end
      chk(pd_en == 4'h0, "R5 all released", int'(pd_en), 0);
      apply(4'h2);
      chk(pd_en == 4'h0, "R5 stays off", int'(pd_en), 0);
      chk(setpoint_mv == 1000, "R9 update", int'(setpoint_mv), 1000);
   endtask

   task automatic t_disable;
      apply(4'h0);
      chk(reg_en == 1'b0,      "R1 disable", int'(reg_en), 0);
      chk(setpoint_mv == 1000, "R3 hold",    int'(setpoint_mv), 1000);
      chk(pd_en == 4'hF,       "R6 rearm",   int'(pd_en), 15);
      repeat (4) @(posedge clk); #1;
      chk(setpoint_mv == 1000, "R3 hold long", int'(setpoint_mv), 1000);
      chk(start_pulse == 1'b0, "R8 no pulse off", int'(start_pulse), 0);
   endtask

   task automatic t_restart;
      apply(4'h8);
      chk(start_pulse == 1'b1, "R8 restart",  int'(start_pulse), 1);
      chk(setpoint_mv == 2300, "R2 sp 1000",  int'(setpoint_mv), 2300);
      chk(pd_en == 4'h7,       "R5 pin3 only", int'(pd_en), 7);
   endtask

   task automatic t_supply;
      @(negedge clk) supply_ok = 1'b0;
      @(posedge clk); #1;
      chk(pd_en == 4'hF,  "R7 forced", int'(pd_en), 15);
      chk(reg_en == 1'b1, "R7 en kept", int'(reg_en), 1);
      @(negedge clk) supply_ok = 1'b1;
      @(posedge clk); #1;
      chk(pd_en == 4'h7,  "R10 supply release", int'(pd_en), 7);
   endtask

   task automatic t_latency;
      @(negedge clk) pin_lvl = 4'h4;
      repeat (2) @(posedge clk); #1;
      chk(setpoint_mv == 2300, "R10 not yet", int'(setpoint_mv), 2300);
      @(posedge clk); #1;
      chk(setpoint_mv == 1400, "R10 third edge", int'(setpoint_mv), 1400);
      chk(start_pulse == 1'b0, "R9 no restart", int'(start_pulse), 0);
   endtask

   initial begin
      #1000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      t_first_enable();
      t_walk_codes();
      t_disable();
      t_restart();
      t_supply();
      t_latency();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule